// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. Software reaches it through a plain register port: an address, write data with a write strobe, and a read strobe with combinational read data. A slow timer tick advances an up-counter, either once per tick or once every 2^N ticks when the prescaler is on. When the counter steps past all ones while the watchdog runs, the block raises its reset request for one cycle and starts again from the load value.

The watchdog can only be stopped or started by writing an exact pair of key words to the key register. Software keeps it alive by writing a new value to the service register, and each new value reloads the counter. Every write is posted: it waits a fixed number of system clock cycles before it takes effect, which stands in for a crossing into the slow domain. While a write waits, its own bit in the pending register is set. The control and load registers are locked while the watchdog runs.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog runs, the load register and the counter read 0xFFFB0000, the control register reads 0, the pending register reads 0 and the reset request is low.
- R2: Writing 0x0000AAAA and then 0x00005555 as consecutive writes to the key register (address 5) stops the counter.
- R3: Writing 0x0000BBBB and then 0x00004444 as consecutive writes to the key register starts the counter.
- R4: If the word after a first key word is not its partner, the pair is dropped, and the run state stays as it was. A partner word with no first word before it has no effect.
- R5: A write to the service register (address 4) whose value differs from the last value taken there reloads the counter from the load register. A write of the same value changes nothing. The last value starts at 0.
- R6: While running, the counter steps by one on each tick when control bit 5 is 0. When bit 5 is 1, it steps once every 2^P ticks, where P is control bits 4:2.
- R7: A step from 0xFFFFFFFF sets the counter to the load value and drives the reset request high for exactly one cycle.
- R8: A write sets its pending bit at once: bit 0 for control (address 1), bit 2 for load (address 3), bit 3 for service, bit 4 for key. The bit stays high for 4 clock cycles, and the new value takes effect in the cycle in which the bit clears.
- R9: Writes to control and load are ignored while the watchdog runs. They take effect while it is stopped.
- R10: Reads: address 0 returns the revision in bits 7:0. Addresses 1 and 3 return control and load, address 2 returns the live counter, and address 6 returns the pending register.
- R11: While stopped, ticks do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timer tick, one-cycle pulse |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read data is zero when low |
| rdata | output | 32 | Read data |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that software writes a register only after its pending bit has cleared. A second write to a busy register is dropped, so the bench always waits out the posting window before it writes the same register again. The assertions also assume that the tick is a single-cycle pulse with idle cycles between pulses. The bench makes every tick one cycle high followed by one cycle low. It keeps the counter away from the all-ones value except in the wrap test, so the reset request pulses exactly once per run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int PTV_W     = 3;
    localparam int DIV_W     = (1 << PTV_W) - 1;
    localparam int NUM_SLOTS = 4;
    localparam int PEND_W    = 5;

    localparam int CTRL_PRE_BIT = 5;
    localparam int CTRL_PTV_LSB = 2;

    localparam logic [31:0] KEY_OFF_A = 32'h0000_AAAA;
    localparam logic [31:0] KEY_OFF_B = 32'h0000_5555;
    localparam logic [31:0] KEY_ON_A  = 32'h0000_BBBB;
    localparam logic [31:0] KEY_ON_B  = 32'h0000_4444;

    typedef enum logic [2:0] {
        RA_REV   = 3'd0,
        RA_CTRL  = 3'd1,
        RA_COUNT = 3'd2,
        RA_LOAD  = 3'd3,
        RA_SVC   = 3'd4,
        RA_KEY   = 3'd5,
        RA_PEND  = 3'd6
    } reg_addr_e;

    typedef enum int {
        SL_CTRL = 0,
        SL_LOAD = 1,
        SL_SVC  = 2,
        SL_KEY  = 3
    } slot_e;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_OFF,
        KS_ARM_ON
    } key_state_e;

    typedef struct packed {
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
    } ctrl_t;

    function automatic logic [2:0] slot_addr(input int slot);
        case (slot)
            SL_CTRL: return RA_CTRL;
            SL_LOAD: return RA_LOAD;
            SL_SVC:  return RA_SVC;
            default: return RA_KEY;
        endcase
    endfunction

    // bit positions of the pending flags; software decodes these
    function automatic int pend_bit(input int slot);
        case (slot)
            SL_CTRL: return 0;
            SL_LOAD: return 2;
            SL_SVC:  return 3;
            default: return 4;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] div_top(input logic [PTV_W-1:0] p);
        return DIV_W'((1 << p) - 1);
    endfunction

endpackage

// File: rtl/wdog_post_slot.sv
module wdog_post_slot #(
    parameter int DW    = 32,
    parameter int DELAY = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          pending,
    output logic          fire,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
            data    <= '0;
        end else if (wr && !pending) begin
            pending <= 1'b1;
            cnt     <= CW'(DELAY - 1);
            data    <= wdata;
        end else if (pending) begin
            if (cnt == '0) pending <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign fire = pending && (cnt == '0);

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && !fire) |=> pending);
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !pending);
    assert_pend_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(wr));

endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [DW-1:0] word,
    output logic          enabled
);
    key_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= KS_IDLE;
            enabled <= 1'b1;
        end else if (fire) begin
            case (state)
                KS_IDLE: begin
                    if (word == DW'(KEY_OFF_A))     state <= KS_ARM_OFF;
                    else if (word == DW'(KEY_ON_A)) state <= KS_ARM_ON;
                end
                KS_ARM_OFF: begin
                    if (word == DW'(KEY_OFF_B)) enabled <= 1'b0;
                    state <= KS_IDLE;
                end
                KS_ARM_ON: begin
                    if (word == DW'(KEY_ON_B)) enabled <= 1'b1;
                    state <= KS_IDLE;
                end
                default: state <= KS_IDLE;
            endcase
        end
    end

    assert_key_only_R2: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(enabled));
    assert_first_word_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && state == KS_IDLE) |=> $stable(enabled));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int          CW         = 32,
    parameter logic [31:0] RESET_LOAD = 32'hFFFB_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  ctrl_t            ctrl,
    input  logic             reload,
    input  logic [CW-1:0]    load_val,
    output logic [CW-1:0]    count,
    output logic             wrap
);
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] top;
    logic             step;

    assign top  = div_top(ctrl.ptv);
    assign step = run && tick && (!ctrl.pre_en || div == top);

    always_ff @(posedge clk) begin
        if (rst || !run || !ctrl.pre_en) begin
            div <= '0;
        end else if (tick) begin
            div <= (div == top) ? '0 : div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CW'(RESET_LOAD);
            wrap  <= 1'b0;
        end else begin
            wrap <= step && (&count) && !reload;
            if (reload)                count <= load_val;
            else if (step && (&count)) count <= load_val;
            else if (step)             count <= count + 1'b1;
        end
    end

    assert_wrap_run_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |-> $past(run));
    assert_wrap_load_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (count == $past(load_val)));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(count));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 3,
    parameter int          POST_DELAY = 4,
    parameter logic [7:0]  REV_ID     = 8'h31,
    parameter logic [31:0] RESET_LOAD = 32'hFFFB_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        DATA_W'(((1 << PTV_W) - 1) << CTRL_PTV_LSB) | (DATA_W'(1) << CTRL_PRE_BIT);

    logic [NUM_SLOTS-1:0] slot_wr;
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_fire;
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] svc_last;
    logic [DATA_W-1:0] count;
    logic [PEND_W-1:0] pend_vec;
    logic              enabled;
    logic              reload;
    ctrl_t             ctrl_f;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_wr[i] = wr_en && (addr == ADDR_W'(slot_addr(i)));
        wdog_post_slot #(.DW(DATA_W), .DELAY(POST_DELAY)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr      (slot_wr[i]),
            .wdata   (wdata),
            .pending (slot_pend[i]),
            .fire    (slot_fire[i]),
            .data    (slot_data[i])
        );
    end

    wdog_key_fsm #(.DW(DATA_W)) u_key (
        .clk     (clk),
        .rst     (rst),
        .fire    (slot_fire[SL_KEY]),
        .word    (slot_data[SL_KEY]),
        .enabled (enabled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= '0;
            load_q    <= DATA_W'(RESET_LOAD);
            svc_last  <= '0;
        end else begin
            if (slot_fire[SL_CTRL] && !enabled) ctrl_word <= slot_data[SL_CTRL] & CTRL_MASK;
            if (slot_fire[SL_LOAD] && !enabled) load_q    <= slot_data[SL_LOAD];
            if (reload)                         svc_last  <= slot_data[SL_SVC];
        end
    end

    assign reload        = slot_fire[SL_SVC] && (slot_data[SL_SVC] != svc_last);
    assign ctrl_f.pre_en = ctrl_word[CTRL_PRE_BIT];
    assign ctrl_f.ptv    = ctrl_word[CTRL_PTV_LSB +: PTV_W];

    wdog_counter #(.CW(DATA_W), .RESET_LOAD(RESET_LOAD)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (enabled),
        .ctrl     (ctrl_f),
        .reload   (reload),
        .load_val (load_q),
        .count    (count),
        .wrap     (rst_req)
    );

    always_comb begin
        pend_vec = '0;
        for (int i = 0; i < NUM_SLOTS; i++) pend_vec[pend_bit(i)] = slot_pend[i];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(RA_REV):   rdata = DATA_W'(REV_ID);
                ADDR_W'(RA_CTRL):  rdata = ctrl_word;
                ADDR_W'(RA_COUNT): rdata = count;
                ADDR_W'(RA_LOAD):  rdata = load_q;
                ADDR_W'(RA_PEND):  rdata = DATA_W'(pend_vec);
                default:           rdata = '0;
            endcase
        end
    end

    assert_load_lock_R9: assert property (@(posedge clk) disable iff (rst)
        enabled |=> $stable(load_q));
    assert_ctrl_lock_R9: assert property (@(posedge clk) disable iff (rst)
        enabled |=> $stable(ctrl_word));
    assert_same_svc_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_fire[SL_SVC] && slot_data[SL_SVC] == svc_last && !enabled) |=> $stable(count));

endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic [31:0] svc_val = 32'h100;

    always #4 clk = ~clk;

    wdog_keyed u_dut (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .rst_req(rst_req)
    );

    always @(negedge clk) if (!rst && rst_req) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1; #1; v = rdata; rd_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wr_only(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_only(a, d);
        repeat (DLY + 1) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic new_svc();
        svc_val = svc_val + 1;
        wr(3'd4, svc_val);
    endtask

    task automatic pend_walk(input string req, input logic [2:0] a, input logic [31:0] d, input int b);
        logic [31:0] v;
        wr_only(a, d);
        for (int k = 0; k < DLY; k++) begin
            rd(3'd6, v);
            check(req, v, 32'(1) << b);
            @(negedge clk);
        end
        rd(3'd6, v);
        check(req, v, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R10: reset state and read map
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rdchk("R10 rev", 3'd0, 32'h31);
        rdchk("R1 ctrl", 3'd1, 32'h0);
        rdchk("R1 load", 3'd3, 32'hFFFB0000);
        rdchk("R1 count", 3'd2, 32'hFFFB0000);
        rdchk("R1 pend", 3'd6, 32'h0);

        // R8 pending flags; R9 ctrl/load ignored while running
        pend_walk("R8 ctrl", 3'd1, 32'h3C, 0);
        pend_walk("R8 load", 3'd3, 32'h10, 2);
        pend_walk("R8 svc", 3'd4, 32'h7, 3);
        pend_walk("R8 key", 3'd5, 32'h1234, 4);
        rdchk("R9 ctrl locked", 3'd1, 32'h0);
        rdchk("R9 load locked", 3'd3, 32'hFFFB0000);

        // R6 plain stepping
        pulse_tick();
        rdchk("R6 step1", 3'd2, 32'hFFFB0001);
        pulse_tick();
        rdchk("R6 step2", 3'd2, 32'hFFFB0002);

        // R5 service reload only on new value (last value is 7)
        wr(3'd4, 32'h55);
        rdchk("R5 reload", 3'd2, 32'hFFFB0000);
        pulse_tick();
        wr(3'd4, 32'h55);
        rdchk("R5 same value", 3'd2, 32'hFFFB0001);
        wr(3'd4, 32'hAA);
        rdchk("R5 new value", 3'd2, 32'hFFFB0000);

        // R4 broken sequences leave it running
        wr(3'd5, 32'hAAAA); wr(3'd5, 32'h1234);
        pulse_tick();
        rdchk("R4 bad second", 3'd2, 32'hFFFB0001);
        wr(3'd5, 32'hAAAA); wr(3'd5, 32'hAAAA); wr(3'd5, 32'h5555);
        pulse_tick();
        rdchk("R4 repeat first", 3'd2, 32'hFFFB0002);
        wr(3'd5, 32'hBBBB); wr(3'd5, 32'h5555);
        pulse_tick();
        rdchk("R4 mixed pair", 3'd2, 32'hFFFB0003);

        // R2 stop; R11 ticks ignored
        wr(3'd5, 32'hAAAA); wr(3'd5, 32'h5555);
        repeat (3) pulse_tick();
        rdchk("R11 stopped", 3'd2, 32'hFFFB0003);
        wr(3'd5, 32'h5555);
        pulse_tick();
        rdchk("R4 lone partner", 3'd2, 32'hFFFB0003);

        // R9 writes land while stopped
        wr(3'd1, 32'hFFFF_FFFF);
        rdchk("R9 ctrl field", 3'd1, 32'h3C);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFE);
        rdchk("R9 load", 3'd3, 32'hFFFFFFFE);
        new_svc();
        rdchk("R5 reload stopped", 3'd2, 32'hFFFFFFFE);

        // R3 start; R7 wrap
        wr(3'd5, 32'hBBBB); wr(3'd5, 32'h4444);
        pulse_tick();
        rdchk("R3 running", 3'd2, 32'hFFFFFFFF);
        check("R7 no early", {31'b0, rst_req}, 32'h0);
        pulse_tick();
        check("R7 pulse", {31'b0, rst_req}, 32'h1);
        rdchk("R7 reload", 3'd2, 32'hFFFFFFFE);
        @(negedge clk);
        check("R7 one cycle", {31'b0, rst_req}, 32'h0);

        // R6 prescaler sweep over every exponent
        for (int p = 0; p < 8; p++) begin
            int n;
            wr(3'd5, 32'hAAAA); wr(3'd5, 32'h5555);
            wr(3'd3, 32'h1000);
            wr(3'd1, 32'h20 | (p << 2));
            new_svc();
            wr(3'd5, 32'hBBBB); wr(3'd5, 32'h4444);
            rd(3'd2, c0);
            n = 0;
            v = c0;
            while (v == c0 && n < 300) begin
                pulse_tick();
                n++;
                rd(3'd2, v);
            end
            check($sformatf("R6 ptv=%0d ticks", p), 32'(n), 32'(1) << p);
            check($sformatf("R6 ptv=%0d value", p), v, 32'h1001);
        end

        check("R7 pulse count", 32'(pulses), 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule